// File: doc/BRIEF.md
# Partitioned SIMD Integer Adder

This block is one wide two's-complement adder whose internal carry path can be cut at fixed slice boundaries. A two-bit type code presented with each operation picks how the word is split. The code selects one of four splits: many narrow lanes, a half-width pair, a quarter-width group, or the whole word as one lane. Each lane adds (or subtracts) its own fields and wraps modulo its own width. No carry ever leaks from one lane into its neighbour, so a single piece of carry logic serves every packed format.

An operation is presented with a valid strobe, two packed operands, the type code and a subtract select. One clock later the packed result appears, together with a carry flag for every slice and a matching output valid. Only the slice at the top of each active lane reports a carry; every other flag reads zero. With the default slice width of 8 the datapath is 64 bits, and the lanes are 8, 16, 32 or 64 bits wide.

Top module: `simd_lane_adder`

## Requirements
- R1: While rst_n is low and until the first accepted operation, out_valid, out_sum and out_cout are all zero.
- R2: out_valid is high in exactly the cycle after a cycle in which in_valid was high at the rising clock edge, and the result of that operation is on out_sum and out_cout in that same cycle.
- R3: A clock edge with in_valid low leaves out_sum and out_cout unchanged, whatever the other inputs carry.
- R4: Type code 2'b00 treats the word as independent 8-bit lanes (lane k occupies bits 8k+7..8k); each lane result is the lane sum modulo 2^8, unaffected by any other lane.
- R5: Type code 2'b01 treats the word as independent 16-bit lanes, each wrapping modulo 2^16.
- R6: Type code 2'b10 treats the word as two independent 32-bit lanes, each wrapping modulo 2^32.
- R7: Type code 2'b11 treats the word as a single 64-bit lane wrapping modulo 2^64.
- R8: With in_sub high each lane yields A minus B modulo the lane width, formed as A plus the inverted B plus one injected at the lane's lowest bit.
- R9: out_cout bit k belongs to the 8-bit slice at bits 8k+7..8k; at the slice holding a lane's most significant bit it is the carry out of that lane's sum (for subtraction: 1 when unsigned A is not below B).
- R10: Every out_cout bit whose slice is not the top slice of an active lane reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation strobe; inputs are taken when high |
| in_a | input | DATA_W (64) | Packed first operand |
| in_b | input | DATA_W (64) | Packed second operand |
| in_fmt | input | 2 | Lane type: 00 = 8-bit, 01 = 16-bit, 10 = 32-bit, 11 = 64-bit |
| in_sub | input | 1 | 1 = subtract B from A in every lane, 0 = add |
| out_valid | output | 1 | High one cycle after an accepted operation |
| out_sum | output | DATA_W (64) | Registered packed result |
| out_cout | output | NUM_SLICES (8) | Carry flag per slice, nonzero only at lane tops |

## Verification
The bench builds the block with its default slice width of 8, giving the 64-bit word with 8/16/32/64-bit lanes, the only setting whose four lane widths line up with the byte-oriented directed patterns. At that size all-ones plus one patterns reach every lane boundary in every format, so a carry that leaks across a cut or is dropped inside a wide lane shows up in both the sum and the flags. Random operands of every type and both operations, mixed with idle cycles carrying junk, cover the hold behaviour and the no-borrow flag polarity of subtraction.

// File: rtl/simd_add_pkg.sv
package simd_add_pkg;

   // Lane type codes; the slice group size of a lane is 1 << code.
   typedef enum logic [1:0] {
      FMT_LANE8  = 2'b00,
      FMT_LANE16 = 2'b01,
      FMT_LANE32 = 2'b10,
      FMT_LANE64 = 2'b11
   } lane_fmt_e;

   // Number of formats equals the number of slice-doubling steps plus one.
   localparam int unsigned FMT_COUNT = 4;
   localparam int unsigned SLICES_PER_WORD = 1 << (FMT_COUNT - 1);

endpackage

// File: rtl/simd_add_lane_map.sv
// Decodes the type code into per-slice lane-start and lane-top markers.
module simd_add_lane_map
   import simd_add_pkg::*;
#(
   parameter int unsigned NUM_SLICES = SLICES_PER_WORD
) (
   input  lane_fmt_e               fmt,
   output logic [NUM_SLICES-1:0]   lane_start,
   output logic [NUM_SLICES-1:0]   lane_top
);
   localparam int unsigned IDX_W = $clog2(NUM_SLICES);

   if (NUM_SLICES != SLICES_PER_WORD) begin : g_bad_slices
      $error("simd_add_lane_map: NUM_SLICES must equal %0d", SLICES_PER_WORD);
   end

   logic [IDX_W-1:0] span_mask;

   always_comb begin
      span_mask = '0;
      for (int unsigned s = 0; s < IDX_W; s++) begin
         if (s < int'(fmt)) span_mask[s] = 1'b1;
      end
   end

   for (genvar i = 0; i < NUM_SLICES; i++) begin : g_slice_pos
      localparam logic [IDX_W-1:0] POS = IDX_W'(i);
      assign lane_start[i] = ((POS & span_mask) == '0);
      assign lane_top[i]   = ((POS & span_mask) == span_mask);
   end

endmodule

// File: rtl/simd_add_slice.sv
// One slice of the adder with an explicit carry in and out.
module simd_add_slice #(
   parameter int unsigned SLICE_W = 8
) (
   input  logic [SLICE_W-1:0] a,
   input  logic [SLICE_W-1:0] b,
   input  logic               cin,
   output logic [SLICE_W-1:0] sum,
   output logic               cout
);
   if (SLICE_W < 1) begin : g_bad_width
      $error("simd_add_slice: SLICE_W must be at least 1");
   end

   logic [SLICE_W:0] wide;

   assign wide = {1'b0, a} + {1'b0, b} + {{SLICE_W{1'b0}}, cin};
   assign sum  = wide[SLICE_W-1:0];
   assign cout = wide[SLICE_W];

endmodule

// File: rtl/simd_add_core.sv
// Combinational partitioned adder: slices chained, chain cut at lane starts.
module simd_add_core
   import simd_add_pkg::*;
#(
   parameter int unsigned SLICE_W    = 8,
   parameter int unsigned NUM_SLICES = SLICES_PER_WORD,
   localparam int unsigned DATA_W    = SLICE_W * NUM_SLICES
) (
   input  logic [DATA_W-1:0]      a,
   input  logic [DATA_W-1:0]      b,
   input  lane_fmt_e              fmt,
   input  logic                   sub,
   output logic [DATA_W-1:0]      sum,
   output logic [NUM_SLICES-1:0]  lane_cout
);
   logic [DATA_W-1:0]     b_eff;
   logic [NUM_SLICES-1:0] start_mark;
   logic [NUM_SLICES-1:0] top_mark;
   logic [NUM_SLICES-1:0] slice_cin;
   logic [NUM_SLICES-1:0] slice_cout;

   assign b_eff = sub ? ~b : b;

   simd_add_lane_map #(
      .NUM_SLICES (NUM_SLICES)
   ) u_map (
      .fmt        (fmt),
      .lane_start (start_mark),
      .lane_top   (top_mark)
   );

   for (genvar i = 0; i < NUM_SLICES; i++) begin : g_chain
      if (i == 0) begin : g_first
         assign slice_cin[i] = sub;
      end else begin : g_rest
         assign slice_cin[i] = start_mark[i] ? sub : slice_cout[i-1];
      end

      simd_add_slice #(
         .SLICE_W (SLICE_W)
      ) u_slice (
         .a    (a[i*SLICE_W +: SLICE_W]),
         .b    (b_eff[i*SLICE_W +: SLICE_W]),
         .cin  (slice_cin[i]),
         .sum  (sum[i*SLICE_W +: SLICE_W]),
         .cout (slice_cout[i])
      );
   end

   assign lane_cout = slice_cout & top_mark;

endmodule

// File: rtl/simd_lane_adder.sv
// Top: partitioned adder with a single output register stage.
module simd_lane_adder
   import simd_add_pkg::*;
#(
   parameter int unsigned SLICE_W    = 8,
   localparam int unsigned NUM_SLICES = SLICES_PER_WORD,
   localparam int unsigned DATA_W     = SLICE_W * NUM_SLICES
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   input  logic [DATA_W-1:0]     in_a,
   input  logic [DATA_W-1:0]     in_b,
   input  logic [1:0]            in_fmt,
   input  logic                  in_sub,
   output logic                  out_valid,
   output logic [DATA_W-1:0]     out_sum,
   output logic [NUM_SLICES-1:0] out_cout
);
   logic [DATA_W-1:0]     comb_sum;
   logic [NUM_SLICES-1:0] comb_cout;

   simd_add_core #(
      .SLICE_W    (SLICE_W),
      .NUM_SLICES (NUM_SLICES)
   ) u_core (
      .a         (in_a),
      .b         (in_b),
      .fmt       (lane_fmt_e'(in_fmt)),
      .sub       (in_sub),
      .sum       (comb_sum),
      .lane_cout (comb_cout)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_sum   <= '0;
         out_cout  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_sum  <= comb_sum;
            out_cout <= comb_cout;
         end
      end
   end

endmodule

// File: rtl/simd_lane_adder_chk.sv
module simd_lane_adder_chk #(
   parameter int unsigned SLICE_W    = 8,
   parameter int unsigned NUM_SLICES = 8,
   localparam int unsigned DATA_W    = SLICE_W * NUM_SLICES
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  in_valid,
   input logic [DATA_W-1:0]     in_a,
   input logic [DATA_W-1:0]     in_b,
   input logic [1:0]            in_fmt,
   input logic                  in_sub,
   input logic                  out_valid,
   input logic [DATA_W-1:0]     out_sum,
   input logic [NUM_SLICES-1:0] out_cout
);
   function automatic logic [NUM_SLICES-1:0] tops_of(input logic [1:0] f);
      logic [NUM_SLICES-1:0] m;
      m = '0;
      for (int k = 0; k < NUM_SLICES; k++) begin
         if (((k + 1) % (1 << f)) == 0) m[k] = 1'b1;
      end
      return m;
   endfunction

   AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid) else $error("valid lost");                    // R2
   AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid) else $error("spurious valid");              // R2
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_sum) && $stable(out_cout)))
      else $error("result changed while idle");                             // R3
   AST_FULL_ADD: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_fmt == 2'b11 && !in_sub) |=>
      (out_sum == $past(in_a) + $past(in_b))) else $error("64-bit add");    // R7
   AST_FULL_SUB: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_fmt == 2'b11 && in_sub) |=>
      (out_sum == $past(in_a) - $past(in_b))) else $error("64-bit sub");    // R8
   AST_FLAG_TOPS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> ((out_cout & ~tops_of($past(in_fmt))) == '0))
      else $error("flag outside lane top");                                 // R10

endmodule

bind simd_lane_adder simd_lane_adder_chk #(
   .SLICE_W    (SLICE_W),
   .NUM_SLICES (NUM_SLICES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_a      (in_a),
   .in_b      (in_b),
   .in_fmt    (in_fmt),
   .in_sub    (in_sub),
   .out_valid (out_valid),
   .out_sum   (out_sum),
   .out_cout  (out_cout)
);

// File: tb/simd_lane_adder_bench.sv
`timescale 1ns/1ps
module simd_lane_adder_bench;
   localparam int DW = 64;
   localparam int NS = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [DW-1:0] in_a = '0;
   logic [DW-1:0] in_b = '0;
   logic [1:0]    in_fmt = 2'b00;
   logic          in_sub = 1'b0;
   logic          out_valid;
   logic [DW-1:0] out_sum;
   logic [NS-1:0] out_cout;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   simd_lane_adder u_simd_lane_adder (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
      .in_fmt(in_fmt), .in_sub(in_sub), .out_valid(out_valid),
      .out_sum(out_sum), .out_cout(out_cout)
   );

   // Behavioural reference state
   logic          m_valid = 1'b0;
   logic [DW-1:0] m_sum = '0;
   logic [NS-1:0] m_cout = '0;
   logic [1:0]    m_fmt = 2'b00;
   bit            m_sub = 1'b0;
   bit            m_loaded = 1'b0;
   bit            m_held = 1'b0;

   function automatic void ref_op(input logic [DW-1:0] a, input logic [DW-1:0] b,
                                  input logic [1:0] f, input bit s,
                                  output logic [DW-1:0] r, output logic [NS-1:0] c);
      int lw;
      int lanes;
      logic [DW:0] mask;
      logic [DW:0] la, lb, t;
      lw = 8 << f;
      lanes = DW / lw;
      mask = (65'd1 << lw) - 65'd1;
      r = '0;
      c = '0;
      for (int j = 0; j < lanes; j++) begin
         la = ({1'b0, a} >> (j * lw)) & mask;
         lb = ({1'b0, b} >> (j * lw)) & mask;
         if (s) lb = (~lb) & mask;
         t = la + lb + (s ? 65'd1 : 65'd0);
         r = r | DW'((t & mask) << (j * lw));
         c[(j + 1) * (1 << f) - 1] = t[lw];
      end
   endfunction

   function automatic logic [NS-1:0] tops(input logic [1:0] f);
      logic [NS-1:0] m;
      m = '0;
      for (int k = 0; k < NS; k++) if (((k + 1) % (1 << f)) == 0) m[k] = 1'b1;
      return m;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_valid <= 1'b0; m_sum <= '0; m_cout <= '0;
         m_loaded <= 1'b0; m_held <= 1'b0;
      end else begin
         logic [DW-1:0] r;
         logic [NS-1:0] c;
         m_valid <= in_valid;
         m_held  <= !in_valid;
         if (in_valid) begin
            ref_op(in_a, in_b, in_fmt, in_sub, r, c);
            m_sum <= r; m_cout <= c; m_fmt <= in_fmt; m_sub <= in_sub;
            m_loaded <= 1'b1;
         end
      end
   end

   function automatic string sum_tag();
      if (!m_loaded) return "R1";
      if (m_held) return "R3";
      if (m_sub) return "R8";
      case (m_fmt)
         2'b00: return "R4";
         2'b01: return "R5";
         2'b10: return "R6";
         default: return "R7";
      endcase
   endfunction

   // Compare on every falling edge
   always @(negedge clk) begin
      if (!finished) begin
         n_cmp++;
         if (out_valid !== m_valid) begin
            n_bad++;
            $display("FAIL %s out_valid actual=%b expected=%b",
                     m_loaded ? "R2" : "R1", out_valid, m_valid);
         end
         n_cmp++;
         if (out_sum !== m_sum) begin
            n_bad++;
            $display("FAIL %s out_sum actual=%h expected=%h", sum_tag(), out_sum, m_sum);
         end
         n_cmp++;
         if (out_cout !== m_cout) begin
            n_bad++;
            if (!m_loaded)
               $display("FAIL R1 out_cout actual=%b expected=%b", out_cout, m_cout);
            else if (m_held)
               $display("FAIL R3 out_cout actual=%b expected=%b", out_cout, m_cout);
            else if ((out_cout & ~tops(m_fmt)) != '0)
               $display("FAIL R10 out_cout actual=%b expected=%b", out_cout, m_cout);
            else
               $display("FAIL R9 out_cout actual=%b expected=%b", out_cout, m_cout);
         end
      end
   end

   task automatic op(input logic [DW-1:0] a, input logic [DW-1:0] b,
                     input logic [1:0] f, input bit s);
      @(negedge clk);
      in_valid = 1'b1; in_a = a; in_b = b; in_fmt = f; in_sub = s;
   endtask

   task automatic idle_junk();
      @(negedge clk);
      in_valid = 1'b0;
      in_a = {$urandom, $urandom}; in_b = {$urandom, $urandom};
      in_fmt = 2'($urandom); in_sub = 1'($urandom);
   endtask

   initial begin
      // R1: reset state observed across several edges with junk inputs
      repeat (3) idle_junk();
      @(negedge clk);
      rst_n = 1'b1;
      idle_junk();
      // R4..R7 and R9: all-ones plus one in every format
      for (int f = 0; f < 4; f++) op('1, 64'h0101_0101_0101_0101, 2'(f), 1'b0);
      for (int f = 0; f < 4; f++) op('1, 64'd1, 2'(f), 1'b0);
      // R4 vs R5: carry must stop or continue at byte boundaries
      op(64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 2'b00, 1'b0);
      op(64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 2'b01, 1'b0);
      op(64'h0000_FFFF_0000_FFFF, 64'h0000_0001_0000_0001, 2'b10, 1'b0);
      // R3: idle cycles with junk must hold the last result
      repeat (3) idle_junk();
      // R8 and R9: subtraction, borrow and no-borrow lanes
      for (int f = 0; f < 4; f++) op(64'h0000_0000_0000_0000, 64'h0101_0101_0101_0101, 2'(f), 1'b1);
      for (int f = 0; f < 4; f++) op(64'h8080_8080_8080_8080, 64'h7F7F_7F7F_7F7F_7F7F, 2'(f), 1'b1);
      op(64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, 2'b11, 1'b1);
      // Random mix with bubbles
      for (int i = 0; i < 600; i++) begin
         if (($urandom % 4) == 0) idle_junk();
         else op({$urandom, $urandom}, {$urandom, $urandom}, 2'($urandom), 1'($urandom));
      end
      // R1: mid-run reset clears the outputs
      op('1, '1, 2'b11, 1'b0);
      @(negedge clk);
      in_valid = 1'b0;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) idle_junk();
      @(negedge clk);
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #50000;
      if (!finished) begin
         finished = 1'b1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog actual=running expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule